// File: doc/BRIEF.md
# AC-link Codec Frame Synchronizer

This block is the codec-side end of a 256-bit serial audio link. It runs on the link bit clock, finds frame boundaries from the rising edge of the frame sync line, and turns the inbound serial stream into a 16-bit tag and twelve 20-bit slots on parallel buses. At the same time it sends a status frame back to the controller: its own tag, followed by twelve slots taken from parallel inputs. Slot 1 carries the command address and slot 2 the command data. Slot 12 carries general-purpose pin control bits inbound and pin status bits outbound.

The block checks the frame spacing continuously. When a sync edge comes early or fails to arrive, the block drops its ready flag and raises mute. It then needs two consecutive correctly spaced frames before it releases them. While lock is lost, the ready bit in the outgoing tag is also cleared, so the controller learns of the loss through the link itself.

Top module: `aclink_codec_sync`

## Requirements
- R1: While rst_ni is low and after its release, before any sync edge: mute_o=1, codec_ready_o=0, rx_frame_o=0, rx_slot_valid_o=0 and link_sdi_o=0.
- R2: Inbound bits are captured on falling clock edges. At the falling edge where link_sync_i is first seen high, the bit captured is F255 of the previous frame, and the next falling edge captures F0. F0..F15 form the tag (F0 is tag bit 15). Slot k (1..12) occupies F(16+20(k-1)) to F(35+20(k-1)), MSB first, and appears on rx_slot_data_o[20(k-1) +: 20].
- R3: A frame is valid when the next sync rise is seen exactly 256 falling edges after the previous one. Lock is gained at the edge that closes the second consecutive valid frame. From that edge, codec_ready_o=1 and mute_o=0; after a single valid frame they remain unchanged.
- R4: A sync rise seen fewer than 256 edges after the previous one drops lock at that edge (mute_o=1, codec_ready_o=0). That rise becomes the phase reference for the next frame.
- R5: If no sync rise is seen at the 256th edge, lock drops at that edge. The next rise only sets the phase, so two further valid frames are needed to regain lock.
- R6: At the edge that closes a valid frame while lock is held, rx_frame_o pulses for one cycle and the tag and slot buses load that frame. At all other times rx_frame_o is 0 and the buses hold their values.
- R7: rx_slot_valid_o[k-1] pulses together with rx_frame_o only when tag bit 15 and tag bit 15-k of that frame are both 1.
- R8: On the rising edge after a sync rise is seen, link_sdi_o carries F0 of a new outbound frame, then one bit per rising edge, MSB first. Outbound tag bits 14..3 are tx_slot_valid_i[0..11], tag bits 2..0 are 0, and slot k carries tx_slot_data_i[20(k-1) +: 20]. Both inputs are sampled at that load edge.
- R9: Outbound tag bit 15 equals the lock state at the load edge, so it is 0 in every frame loaded while lock is lost.
- R10: Slot 12 (inbound F236..F255 and outbound the same positions) is carried in both directions like any other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| link_sync_i | input | 1 | Frame sync from the controller, active high |
| link_sdo_i | input | 1 | Serial data from the controller |
| link_sdi_o | output | 1 | Serial data to the controller |
| rx_frame_o | output | 1 | One-cycle pulse when an accepted frame is loaded |
| rx_tag_o | output | 16 | Tag slot of the last accepted frame |
| rx_slot_data_o | output | 240 | Slots 1..12 of the last accepted frame |
| rx_slot_valid_o | output | 12 | Per-slot valid strobes, gated by tag bits |
| tx_slot_data_i | input | 240 | Outbound slots 1..12 |
| tx_slot_valid_i | input | 12 | Outbound per-slot valid bits for the tag |
| codec_ready_o | output | 1 | High while frame lock is held |
| mute_o | output | 1 | High while frame lock is lost |

## Verification
The hardest situation to reach is a loss of lock caused by a missing sync edge once lock has already been gained. Detecting it requires the block to notice the absence of an edge at a precise count, and recovering requires it to treat the next edge as phase only. The stimulus reaches this case by stretching one frame to 300 cycles after lock. It then watches mute through the stretch and over the following three frames. Throughout, the serial return line is captured bit by bit, which shows that the ready bit in the outgoing tag stays clear for the frames loaded while lock is lost.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int unsigned TAG_BITS    = 16;
  localparam int unsigned SLOT_BITS   = 20;
  localparam int unsigned DATA_SLOTS  = 12;
  localparam int unsigned LOCK_FRAMES = 2;

  // Highest frame-vector index of data slot k (0-based); the vector's MSB is F0.
  function automatic int unsigned slot_top(int unsigned frame_w, int unsigned tag_w,
                                           int unsigned slot_w, int unsigned k);
    return frame_w - 1 - tag_w - k * slot_w;
  endfunction
endpackage

// File: rtl/aclink_lock_fsm.sv
module aclink_lock_fsm #(
  parameter int unsigned FRAME_W     = 256,
  parameter int unsigned LOCK_FRAMES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic accept_o,
  output logic frame_edge_o,
  output logic locked_o
);
  localparam int unsigned POS_W = $clog2(FRAME_W);
  localparam int unsigned CNT_W = $clog2(LOCK_FRAMES + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(LOCK_FRAMES);

  logic             sync_q, phased_q, locked_q, edge_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] good_q, good_nxt;
  logic             rise, due, good, bad, lock_nxt;

  always_comb begin
    rise = sync_i & ~sync_q;
    // pos_q is the frame position of the bit taken at this edge
    due  = phased_q & (pos_q == LAST_POS);
    good = rise & due;
    bad  = (rise & phased_q & ~due) | (due & ~rise);
    good_nxt = good_q;
    if (bad) good_nxt = '0;
    else if (good && good_q != CNT_TOP) good_nxt = good_q + 1'b1;
    lock_nxt = locked_q;
    if (bad) lock_nxt = 1'b0;
    else if (good && good_nxt == CNT_TOP) lock_nxt = 1'b1;
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      phased_q <= 1'b0;
      locked_q <= 1'b0;
      edge_q   <= 1'b0;
      pos_q    <= '0;
      good_q   <= '0;
    end else begin
      sync_q   <= sync_i;
      edge_q   <= rise;
      phased_q <= rise | (phased_q & ~due);
      pos_q    <= (rise || pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
      good_q   <= good_nxt;
      locked_q <= lock_nxt;
    end
  end

  assign accept_o     = good & lock_nxt;
  assign frame_edge_o = edge_q;
  assign locked_o     = locked_q;
endmodule

// File: rtl/aclink_rx_deser.sv
module aclink_rx_deser
  import aclink_pkg::*;
#(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sdo_i,
  input  logic                        accept_i,
  output logic                        frame_o,
  output logic [TAG_W-1:0]            tag_o,
  output logic [NUM_SLOTS*SLOT_W-1:0] data_o,
  output logic [NUM_SLOTS-1:0]        valid_o
);
  localparam int unsigned FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  logic [FRAME_W-2:0]   sr_q;
  logic [FRAME_W-1:0]   frm;
  logic [TAG_W-1:0]     tag_q;
  logic [NUM_SLOTS-1:0] valid_d, valid_q;
  logic                 frame_q;

  // Bit taken at the closing edge is F255
  assign frm = {sr_q, sdo_i};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      tag_q   <= '0;
      valid_q <= '0;
      frame_q <= 1'b0;
    end else begin
      sr_q    <= {sr_q[FRAME_W-3:0], sdo_i};
      frame_q <= accept_i;
      valid_q <= valid_d;
      if (accept_i) tag_q <= frm[FRAME_W-1 -: TAG_W];
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int unsigned TOP = slot_top(FRAME_W, TAG_W, SLOT_W, k);
    logic [SLOT_W-1:0] data_q;

    assign valid_d[k] = accept_i & frm[FRAME_W-1] & frm[FRAME_W-2-k];

    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       data_q <= '0;
      else if (accept_i) data_q <= frm[TOP -: SLOT_W];
    end

    assign data_o[k*SLOT_W +: SLOT_W] = data_q;
  end

  assign frame_o = frame_q;
  assign tag_o   = tag_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/aclink_tx_ser.sv
module aclink_tx_ser
  import aclink_pkg::*;
#(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_i,
  input  logic                        ready_i,
  input  logic [NUM_SLOTS*SLOT_W-1:0] data_i,
  input  logic [NUM_SLOTS-1:0]        valid_i,
  output logic                        sdi_o
);
  localparam int unsigned FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  logic [FRAME_W-1:0] vec;
  logic [FRAME_W-2:0] sr_q;
  logic               bit_q;

  always_comb begin
    vec = '0;
    vec[FRAME_W-1] = ready_i;
    for (int unsigned k = 0; k < NUM_SLOTS; k++) begin
      vec[FRAME_W-2-k] = valid_i[k];
      vec[slot_top(FRAME_W, TAG_W, SLOT_W, k) -: SLOT_W] = data_i[k*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      bit_q <= 1'b0;
    end else if (load_i) begin
      bit_q <= vec[FRAME_W-1];
      sr_q  <= vec[FRAME_W-2:0];
    end else begin
      bit_q <= sr_q[FRAME_W-2];
      sr_q  <= {sr_q[FRAME_W-3:0], 1'b0};
    end
  end

  assign sdi_o = bit_q;
endmodule

// File: rtl/aclink_codec_sync.sv
module aclink_codec_sync
  import aclink_pkg::*;
#(
  parameter int unsigned TAG_W       = TAG_BITS,
  parameter int unsigned SLOT_W      = SLOT_BITS,
  parameter int unsigned NUM_SLOTS   = DATA_SLOTS,
  parameter int unsigned LOCK_FRAMES = aclink_pkg::LOCK_FRAMES
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        link_sync_i,
  input  logic                        link_sdo_i,
  output logic                        link_sdi_o,
  output logic                        rx_frame_o,
  output logic [TAG_W-1:0]            rx_tag_o,
  output logic [NUM_SLOTS*SLOT_W-1:0] rx_slot_data_o,
  output logic [NUM_SLOTS-1:0]        rx_slot_valid_o,
  input  logic [NUM_SLOTS*SLOT_W-1:0] tx_slot_data_i,
  input  logic [NUM_SLOTS-1:0]        tx_slot_valid_i,
  output logic                        codec_ready_o,
  output logic                        mute_o
);
  localparam int unsigned FRAME_W = TAG_W + NUM_SLOTS * SLOT_W;

  logic accept, frame_edge, locked;

  aclink_lock_fsm #(
    .FRAME_W    (FRAME_W),
    .LOCK_FRAMES(LOCK_FRAMES)
  ) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sync_i      (link_sync_i),
    .accept_o    (accept),
    .frame_edge_o(frame_edge),
    .locked_o    (locked)
  );

  aclink_rx_deser #(
    .TAG_W    (TAG_W),
    .SLOT_W   (SLOT_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sdo_i   (link_sdo_i),
    .accept_i(accept),
    .frame_o (rx_frame_o),
    .tag_o   (rx_tag_o),
    .data_o  (rx_slot_data_o),
    .valid_o (rx_slot_valid_o)
  );

  aclink_tx_ser #(
    .TAG_W    (TAG_W),
    .SLOT_W   (SLOT_W),
    .NUM_SLOTS(NUM_SLOTS)
  ) u_tx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (frame_edge),
    .ready_i(locked),
    .data_i (tx_slot_data_i),
    .valid_i(tx_slot_valid_i),
    .sdi_o  (link_sdi_o)
  );

  assign codec_ready_o = locked;
  assign mute_o        = ~locked;
endmodule

// File: rtl/aclink_sync_chk.sv
module aclink_sync_chk #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned NUM_SLOTS = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 link_sync_i,
  input logic                 rx_frame_o,
  input logic [TAG_W-1:0]     rx_tag_o,
  input logic [NUM_SLOTS-1:0] rx_slot_valid_o,
  input logic                 codec_ready_o,
  input logic                 mute_o
);
  a_r3_unmute_on_sync_rise: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> ($past(link_sync_i) && !$past(link_sync_i, 2)));

  a_r6_frame_on_sync_rise: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rx_frame_o |-> ($past(link_sync_i) && !$past(link_sync_i, 2)));

  a_r6_frame_single_pulse: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rx_frame_o |=> !rx_frame_o);

  a_r6_frame_needs_lock: assert property (@(negedge clk_i) disable iff (!rst_ni)
    rx_frame_o |-> (codec_ready_o && !mute_o));

  a_r6_tag_holds: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !rx_frame_o |-> $stable(rx_tag_o));

  a_r7_valid_gated: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (|rx_slot_valid_o) |-> (rx_frame_o && rx_tag_o[TAG_W-1]));
endmodule

bind aclink_codec_sync aclink_sync_chk #(
  .TAG_W    (TAG_W),
  .NUM_SLOTS(NUM_SLOTS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .link_sync_i    (link_sync_i),
  .rx_frame_o     (rx_frame_o),
  .rx_tag_o       (rx_tag_o),
  .rx_slot_valid_o(rx_slot_valid_o),
  .codec_ready_o  (codec_ready_o),
  .mute_o         (mute_o)
);

// File: tb/aclink_codec_sync_test.sv
`timescale 1ns/1ps
module aclink_codec_sync_test;
  logic         clk = 1'b0;
  logic         rst_ni;
  logic         link_sync_i, link_sdo_i, link_sdi_o;
  logic         rx_frame_o, codec_ready_o, mute_o;
  logic [15:0]  rx_tag_o;
  logic [239:0] rx_slot_data_o, tx_slot_data_i;
  logic [11:0]  rx_slot_valid_o, tx_slot_valid_i;

  int n_chk = 0;
  int n_fail = 0;

  logic         prev_last = 1'b0;
  logic [255:0] cap_cur = '0, cap_done = '0;
  logic         obs_frame, obs_mute, obs_ready, end_mute;
  logic [15:0]  obs_tag;
  logic [239:0] obs_data;
  logic [11:0]  obs_valid;

  always #4 clk = ~clk;

  aclink_codec_sync uut (
    .clk_i(clk), .rst_ni(rst_ni), .link_sync_i(link_sync_i), .link_sdo_i(link_sdo_i),
    .link_sdi_o(link_sdi_o), .rx_frame_o(rx_frame_o), .rx_tag_o(rx_tag_o),
    .rx_slot_data_o(rx_slot_data_o), .rx_slot_valid_o(rx_slot_valid_o),
    .tx_slot_data_i(tx_slot_data_i), .tx_slot_valid_i(tx_slot_valid_i),
    .codec_ready_o(codec_ready_o), .mute_o(mute_o)
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Frame vector index 255-p holds F_p
  function automatic logic [255:0] mk_frame(logic [15:0] tag, logic [19:0] seed);
    logic [255:0] fv;
    fv[255:240] = tag;
    for (int k = 0; k < 12; k++) fv[239-20*k -: 20] = 20'h80001 ^ (seed + 20'(k * 4099));
    return fv;
  endfunction

  function automatic logic [239:0] slots_of(logic [255:0] fv);
    logic [239:0] d;
    for (int k = 0; k < 12; k++) d[k*20 +: 20] = fv[239-20*k -: 20];
    return d;
  endfunction

  function automatic logic [11:0] valid_of(logic [15:0] tag);
    logic [11:0] v;
    for (int k = 0; k < 12; k++) v[k] = tag[15] & tag[14-k];
    return v;
  endfunction

  function automatic logic [255:0] exp_tx(logic rdy, logic [11:0] v, logic [239:0] d);
    logic [255:0] fv;
    fv = '0;
    fv[255] = rdy;
    for (int k = 0; k < 12; k++) begin
      fv[254-k] = v[k];
      fv[239-20*k -: 20] = d[k*20 +: 20];
    end
    return fv;
  endfunction

  // Cycle 0 carries the sync rise and F255 of the previous frame
  task automatic emit(logic [255:0] fv, int period);
    for (int c = 0; c < period; c++) begin
      @(posedge clk); #1;
      link_sync_i = (c < 16);
      if (c == 0)        link_sdo_i = prev_last;
      else if (c <= 255) link_sdo_i = fv[256-c];
      else               link_sdo_i = 1'b0;
      @(negedge clk); #1;
      if (c == 0) begin
        cap_cur[0] = link_sdi_o;
        cap_done   = cap_cur;
        obs_frame  = rx_frame_o;
        obs_mute   = mute_o;
        obs_ready  = codec_ready_o;
        obs_tag    = rx_tag_o;
        obs_data   = rx_slot_data_o;
        obs_valid  = rx_slot_valid_o;
      end else if (c <= 255) begin
        cap_cur[256-c] = link_sdi_o;
      end
    end
    prev_last = fv[0];
    end_mute  = mute_o;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; link_sync_i = 1'b0; link_sdo_i = 1'b0;
    tx_slot_data_i = '0; tx_slot_valid_i = '0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 mute", 256'(mute_o), 256'(1));
    chk("R1 ready", 256'(codec_ready_o), 256'(0));
    chk("R1 frame", 256'(rx_frame_o), 256'(0));
    chk("R1 valid", 256'(rx_slot_valid_o), 256'(0));
    chk("R1 sdi", 256'(link_sdi_o), 256'(0));
  endtask

  task automatic t_acquire();
    logic [255:0] fa, fb, fc, fd;
    tx_slot_data_i  = slots_of(mk_frame(16'h0, 20'h3C3C1));
    tx_slot_valid_i = 12'hA5C;
    fa = mk_frame(16'hFFF8, 20'h11111);
    fb = mk_frame(16'hA038, 20'h2A2A2);   // frame valid, slots 2,10,11,12
    fc = mk_frame(16'h7FF8, 20'h55555);   // frame-valid bit clear
    fd = mk_frame(16'hC000, 20'h0F0F0);
    emit(fa, 256);
    emit(fb, 256);
    chk("R3 one valid frame keeps mute", 256'(obs_mute), 256'(1));
    chk("R6 no frame before lock", 256'(obs_frame), 256'(0));
    emit(fc, 256);
    chk("R3 lock mute", 256'(obs_mute), 256'(0));
    chk("R3 lock ready", 256'(obs_ready), 256'(1));
    chk("R6 frame pulse", 256'(obs_frame), 256'(1));
    chk("R2 tag", 256'(obs_tag), 256'(fb[255:240]));
    chk("R2 slots", 256'(obs_data), 256'(slots_of(fb)));
    chk("R7 valid mask", 256'(obs_valid), 256'(valid_of(fb[255:240])));
    chk("R10 slot12 in", 256'(obs_data[239:220]), 256'(fb[19:0]));
    chk("R9 tag ready clear before lock", cap_done, exp_tx(1'b0, 12'hA5C, tx_slot_data_i));
    emit(fd, 256);
    chk("R7 no valid when tag bit15 clear", 256'(obs_valid), 256'(0));
    chk("R6 frame after tag", 256'(obs_tag), 256'(fc[255:240]));
    chk("R8 tx frame", cap_done, exp_tx(1'b1, 12'hA5C, tx_slot_data_i));
    chk("R10 slot12 out", 256'(cap_done[19:0]), 256'(tx_slot_data_i[239:220]));
  endtask

  task automatic t_early();
    logic [255:0] fe, ff, fg, fh, fi;
    fe = mk_frame(16'hFFF8, 20'h12345);
    ff = mk_frame(16'hFFF8, 20'h6789A);
    fg = mk_frame(16'hFFF8, 20'hBCDEF);
    fh = mk_frame(16'h8008, 20'h02468);
    fi = mk_frame(16'hFFF8, 20'h13579);
    emit(fe, 200);
    tx_slot_data_i  = slots_of(mk_frame(16'h0, 20'h7E7E7));
    tx_slot_valid_i = 12'h3C1;
    emit(ff, 256);
    chk("R4 early sync mute", 256'(obs_mute), 256'(1));
    chk("R4 early sync ready", 256'(obs_ready), 256'(0));
    chk("R4 early sync no frame", 256'(obs_frame), 256'(0));
    emit(fg, 256);
    chk("R3 single frame after loss keeps mute", 256'(obs_mute), 256'(1));
    chk("R9 tag ready clear on early loss", 256'(cap_done[255]), 256'(0));
    emit(fh, 256);
    chk("R4 relock mute", 256'(obs_mute), 256'(0));
    chk("R6 relock slots", 256'(obs_data), 256'(slots_of(fg)));
    emit(fi, 256);
    chk("R8 tx frame after relock", cap_done, exp_tx(1'b1, 12'h3C1, tx_slot_data_i));
    chk("R7 sparse mask", 256'(obs_valid), 256'(valid_of(fh[255:240])));
  endtask

  task automatic t_miss();
    logic [255:0] fj, fk, fl, fm;
    fj = mk_frame(16'hFFF8, 20'hAAAAA);
    fk = mk_frame(16'hFFF8, 20'h33333);
    fl = mk_frame(16'hFFF8, 20'h44444);
    fm = mk_frame(16'hFFF8, 20'h66666);
    emit(fj, 300);
    chk("R5 still locked at last good rise", 256'(obs_mute), 256'(0));
    chk("R5 missing sync mute", 256'(end_mute), 256'(1));
    emit(fk, 256);
    chk("R5 phase-only rise keeps mute", 256'(obs_mute), 256'(1));
    chk("R5 phase-only rise no frame", 256'(obs_frame), 256'(0));
    chk("R6 buses hold", 256'(obs_tag), 256'(16'hFFF8));
    emit(fl, 256);
    chk("R5 one valid frame keeps mute", 256'(obs_mute), 256'(1));
    chk("R9 tag ready clear on miss", 256'(cap_done[255]), 256'(0));
    emit(fm, 256);
    chk("R5 relock ready", 256'(obs_ready), 256'(1));
    chk("R5 relock slots", 256'(obs_data), 256'(slots_of(fl)));
  endtask

  initial begin
    t_reset();
    t_acquire();
    t_early();
    t_miss();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL all watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule